// File: doc/BRIEF.md
# Bit-Clock and Frame-Sync Generator

This block produces the timing for a serial audio port. It divides a fast input clock down to a bit clock. It counts bit periods to mark out frames, and it drives a frame-sync pulse at the start of each frame. Software-facing logic sits outside the block and supplies one packed configuration word, which carries the following fields:

| Field | Bits | Meaning |
|---|---|---|
| divider | [7:0] | bit period = value + 1 input ticks |
| pulse width | [15:8] | sync active for value + 1 bit periods |
| frame period | [27:16] | frame = value + 1 bit periods |
| free-run mode | [28] | 1 = a frame follows every period |

Two enables gate the block. The generator enable lets clocks run at all. The frame-sync enable lets frames be produced.

The divider input is either the local clock, which gives one tick per cycle, or an alternate slow clock pin. The alternate pin is resynchronised, and each of its rising edges counts as one tick. The bit clock has a selectable polarity. The transmit and receive frame syncs have independent polarities.

Two strobes tell the data shifters outside the block where they are in the bit period. `bit_stb` marks the receive sample point and `tx_stb` marks the transmit change point. A new divider, period or width value takes effect only at a frame boundary, so no frame ever has an irregular length. When no frame is running, the new value also takes effect at any bit boundary, and it is taken directly while the generator is disabled.

Top module: `frame_clock_gen`

## Requirements
- R1: With the local source and the generator enabled, `bit_stb` pulses once every (divider + 1) clock cycles. Inside each bit period the internal clock is high for the first floor(divider/2) + 1 cycles and low for the rest.
- R2: When `clk_pol` = 1, `bclk` equals the internal clock. When `clk_pol` = 0, `bclk` is its inverse. `bit_stb` is high in the cycle just before the internal clock rises, which is the receive sample point. `tx_stb` is high in the cycle just before it falls, which is the transmit change point.
- R3: A frame lasts (period + 1) bit periods. The frame sync becomes active in the cycle after the `bit_stb` that starts the frame.
- R4: The frame sync is active for the first (width + 1) bit periods of each frame. It stays active for the whole frame when width >= period.
- R5: `fs_tx` is active low when `fs_pol_tx` = 1 and active high when it is 0. `fs_rx` follows `fs_pol_rx` in the same way, independently of `fs_tx`.
- R6: When bit 28 = 1, frames follow one another without gaps. When bit 28 = 0, a frame starts at a bit boundary only after a one-cycle pulse on `xfer_req`, and the frame sync stays inactive otherwise.
- R7: With `gen_en` = 0 there are no strobes and no frame syncs, and `bclk` sits at its idle level. With `fs_en` = 0 the clocks keep running but the frame syncs are inactive.
- R8: A change of divider, period or width while a frame is running takes effect only at the next frame boundary.
- R9: With `src_sel` = 1, each rising edge of `ext_clk` counts as one divider tick after a two-flop resynchroniser. If `ext_clk` does not toggle, no `bit_stb` occurs.
- R10: During reset, `bit_stb` and `tx_stb` are low, `bclk` is at its idle level, and each frame sync is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 29 | Divider [7:0], width [15:8], period [27:16], free-run [28] |
| gen_en | input | 1 | Generator enable |
| fs_en | input | 1 | Frame-sync enable |
| clk_pol | input | 1 | Bit clock polarity |
| fs_pol_tx | input | 1 | Transmit sync active low when 1 |
| fs_pol_rx | input | 1 | Receive sync active low when 1 |
| src_sel | input | 1 | 1 selects the alternate clock pin as divider input |
| ext_clk | input | 1 | Alternate clock pin |
| xfer_req | input | 1 | Frame request pulse for non-free-run mode |
| bit_stb | output | 1 | Bit boundary / receive sample strobe |
| tx_stb | output | 1 | Transmit change strobe |
| bclk | output | 1 | Bit clock |
| fs_tx | output | 1 | Transmit frame sync |
| fs_rx | output | 1 | Receive frame sync |

## Verification
The bench builds the block with its default widths: an 8-bit divider, an 8-bit width field and a 12-bit period field. It uses the alternate clock path with a two-stage resynchroniser. Small field values reach the interesting points within a few hundred cycles. These include a divider of zero, odd and even divisors, and a width that reaches or exceeds the period. The bench also rewrites the configuration in the middle of a frame and holds a request-paced frame idle. Slow alternate clock edges are compared against the same cycle model as the local source.

// File: rtl/fsg_pkg.sv
`timescale 1ns/1ps
package fsg_pkg;
   localparam int DEF_DIV_W = 8;
   localparam int DEF_WID_W = 8;
   localparam int DEF_PER_W = 12;
   typedef enum logic {FR_IDLE = 1'b0, FR_RUN = 1'b1} frame_st_e;
endpackage

// File: rtl/fsg_tick_src.sv
`timescale 1ns/1ps
module fsg_tick_src #(
   parameter bit HAS_EXT     = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_sel,
   input  logic ext_clk,
   output logic tick
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("fsg_tick_src: SYNC_STAGES must be at least 2");
      end
      if (HAS_EXT) begin : g_ext
         logic [SYNC_STAGES:0] sh;
         logic                 rise;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[SYNC_STAGES-1:0], ext_clk};
         end
         assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
         assign tick = src_sel ? rise : 1'b1;
         // R9
         ext_edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise |=> !rise);
      end else begin : g_local
         logic unused_pins;
         assign unused_pins = src_sel ^ ext_clk;
         assign tick = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/fsg_bit_div.sv
`timescale 1ns/1ps
module fsg_bit_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gen_en,
   input  logic             tick,
   input  logic             ld_ok,
   input  logic [DIV_W-1:0] div_cfg,
   output logic             wrap,
   output logic             half_stb,
   output logic             raw
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] div_a;
   logic [DIV_W-1:0] half;

   assign half     = div_a >> 1;
   assign wrap     = gen_en & tick & (cnt == div_a);
   assign half_stb = gen_en & tick & (cnt == half);
   assign raw      = gen_en & (cnt <= half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         div_a <= '0;
      end else if (!gen_en) begin
         cnt   <= '0;
         div_a <= div_cfg;
      end else begin
         if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
         if (ld_ok) div_a <= div_cfg;
      end
   end

   // R1
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= div_a);
   // R2
   clk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_en && $past(gen_en) && $rose(raw)) |-> $past(wrap));
endmodule

// File: rtl/fsg_frame.sv
`timescale 1ns/1ps
module fsg_frame
   import fsg_pkg::*;
#(
   parameter int PER_W = 12,
   parameter int WID_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gen_en,
   input  logic             fs_en,
   input  logic             wrap,
   input  logic             mode,
   input  logic             xfer_req,
   input  logic [PER_W-1:0] per_cfg,
   input  logic [WID_W-1:0] wid_cfg,
   output logic             frame_edge,
   output logic             fs_raw
);
   frame_st_e        st;
   logic [PER_W-1:0] pcnt;
   logic [PER_W-1:0] per_a;
   logic [WID_W-1:0] wid_a;
   logic             pend;
   logic             req;
   logic             start;

   assign req        = pend | xfer_req;
   assign start      = mode | req;
   assign frame_edge = wrap & ((st == FR_IDLE) | (pcnt == per_a));
   assign fs_raw     = (st == FR_RUN) & (pcnt <= PER_W'(wid_a));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= FR_IDLE;
         pcnt  <= '0;
         per_a <= '0;
         wid_a <= '0;
         pend  <= 1'b0;
      end else if (!gen_en) begin
         st    <= FR_IDLE;
         pcnt  <= '0;
         pend  <= 1'b0;
         per_a <= per_cfg;
         wid_a <= wid_cfg;
      end else begin
         if (frame_edge) begin
            per_a <= per_cfg;
            wid_a <= wid_cfg;
         end
         if (!fs_en) begin
            st   <= FR_IDLE;
            pcnt <= '0;
            pend <= 1'b0;
         end else if (frame_edge) begin
            pcnt <= '0;
            if (start) begin
               st   <= FR_RUN;
               pend <= 1'b0;
            end else begin
               st   <= FR_IDLE;
               pend <= req;
            end
         end else begin
            if (wrap) pcnt <= pcnt + 1'b1;
            pend <= req;
         end
      end
   end

   // R3
   pcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FR_RUN) |-> (pcnt <= per_a));
   // R8
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_en && st == FR_RUN && !frame_edge) |=> ($stable(per_a) && $stable(wid_a)));
   // R6
   paced_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FR_IDLE && !mode && !pend && !xfer_req) |=> (st == FR_IDLE));
   // R7
   gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |=> (st == FR_IDLE && pcnt == '0));
endmodule

// File: rtl/frame_clock_gen.sv
`timescale 1ns/1ps
module frame_clock_gen
   import fsg_pkg::*;
#(
   parameter int DIV_W       = DEF_DIV_W,
   parameter int WID_W       = DEF_WID_W,
   parameter int PER_W       = DEF_PER_W,
   parameter bit HAS_EXT     = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [DIV_W+WID_W+PER_W:0]   cfg_word,
   input  logic                         gen_en,
   input  logic                         fs_en,
   input  logic                         clk_pol,
   input  logic                         fs_pol_tx,
   input  logic                         fs_pol_rx,
   input  logic                         src_sel,
   input  logic                         ext_clk,
   input  logic                         xfer_req,
   output logic                         bit_stb,
   output logic                         tx_stb,
   output logic                         bclk,
   output logic                         fs_tx,
   output logic                         fs_rx
);
   localparam int WID_LSB  = DIV_W;
   localparam int PER_LSB  = WID_LSB + WID_W;
   localparam int MODE_BIT = PER_LSB + PER_W;

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("frame_clock_gen: DIV_W must be positive");
      end
      if (WID_W > PER_W) begin : g_bad_wid
         $error("frame_clock_gen: WID_W must not exceed PER_W");
      end
   endgenerate

   logic tick;
   logic wrap;
   logic half_stb;
   logic raw;
   logic frame_edge;
   logic fs_raw;

   fsg_tick_src #(.HAS_EXT(HAS_EXT), .SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_clk(ext_clk), .tick(tick));

   fsg_bit_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .tick(tick), .ld_ok(frame_edge),
      .div_cfg(cfg_word[DIV_W-1:0]), .wrap(wrap), .half_stb(half_stb), .raw(raw));

   fsg_frame #(.PER_W(PER_W), .WID_W(WID_W)) u_frm (
      .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .fs_en(fs_en), .wrap(wrap),
      .mode(cfg_word[MODE_BIT]), .xfer_req(xfer_req),
      .per_cfg(cfg_word[MODE_BIT-1:PER_LSB]), .wid_cfg(cfg_word[PER_LSB-1:WID_LSB]),
      .frame_edge(frame_edge), .fs_raw(fs_raw));

   assign bit_stb = wrap;
   assign tx_stb  = half_stb;
   assign bclk    = clk_pol ? raw : ~raw;
   assign fs_tx   = fs_raw ^ fs_pol_tx;
   assign fs_rx   = fs_raw ^ fs_pol_rx;

   // R3
   fs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fs_raw) |-> $past(wrap));
   // R7
   fs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fs_en |=> !fs_raw);
endmodule

// File: tb/frame_clock_gen_test.sv
`timescale 1ns/1ps
module frame_clock_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [28:0] cfg_word = '0;
   logic        gen_en = 1'b0, fs_en = 1'b0, clk_pol = 1'b1;
   logic        fs_pol_tx = 1'b0, fs_pol_rx = 1'b1;
   logic        src_sel = 1'b0, ext_clk = 1'b0, xfer_req = 1'b0;
   logic        bit_stb, tx_stb, bclk, fs_tx, fs_rx;

   int    checks = 0;
   int    errors = 0;
   bit    started = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R10";

   // reference model state
   int m_cnt = 0, m_div = 0, m_per = 0, m_wid = 0, m_pcnt = 0;
   int m_run = 0, m_pend = 0, s1 = 0, s2 = 0, s3 = 0;
   int t_tick, t_wrap, t_fe, t_req;

   frame_clock_gen uut (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .gen_en(gen_en), .fs_en(fs_en),
      .clk_pol(clk_pol), .fs_pol_tx(fs_pol_tx), .fs_pol_rx(fs_pol_rx),
      .src_sel(src_sel), .ext_clk(ext_clk), .xfer_req(xfer_req),
      .bit_stb(bit_stb), .tx_stb(tx_stb), .bclk(bclk), .fs_tx(fs_tx), .fs_rx(fs_rx));

   always #10 clk = ~clk;

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   // cycle model: state update on each rising edge
   always @(posedge clk) begin
      started <= 1'b1;
      if (!rst_n) begin
         m_cnt = 0; m_div = 0; m_per = 0; m_wid = 0; m_pcnt = 0;
         m_run = 0; m_pend = 0; s1 = 0; s2 = 0; s3 = 0;
      end else begin
         t_tick = src_sel ? (s2 && !s3) : 1;
         t_wrap = gen_en && t_tick && (m_cnt == m_div);
         t_fe   = t_wrap && (!m_run || m_pcnt == m_per);
         t_req  = m_pend || xfer_req;
         if (!gen_en) begin
            m_cnt = 0; m_run = 0; m_pcnt = 0; m_pend = 0;
            m_div = cfg_word[7:0]; m_wid = cfg_word[15:8]; m_per = cfg_word[27:16];
         end else begin
            if (t_tick) m_cnt = t_wrap ? 0 : m_cnt + 1;
            if (!fs_en) begin
               m_run = 0; m_pcnt = 0; m_pend = 0;
            end else if (t_fe) begin
               m_pcnt = 0;
               if (cfg_word[28] || t_req) begin m_run = 1; m_pend = 0; end
               else begin m_run = 0; m_pend = t_req; end
            end else begin
               if (t_wrap) m_pcnt = m_pcnt + 1;
               m_pend = t_req;
            end
            if (t_fe) begin
               m_div = cfg_word[7:0]; m_wid = cfg_word[15:8]; m_per = cfg_word[27:16];
            end
         end
         s3 = s2; s2 = s1; s1 = ext_clk;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (started && !done) begin
         int tk, raw, fsr;
         tk  = src_sel ? (s2 && !s3) : 1;
         raw = gen_en && (m_cnt <= m_div / 2);
         fsr = m_run && (m_pcnt <= m_wid);
         chk("bclk", bclk, clk_pol ? raw : !raw);
         chk("bit_stb", bit_stb, gen_en && tk && m_cnt == m_div);
         chk("tx_stb", tx_stb, gen_en && tk && m_cnt == m_div / 2);
         chk("fs_tx", fs_tx, fsr ^ fs_pol_tx);
         chk("fs_rx", fs_rx, fsr ^ fs_pol_rx);
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic set_cfg(input int dv, input int wd, input int pr, input int md);
      cfg_word = {md[0], pr[11:0], wd[7:0], dv[7:0]};
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      cur_req = "watchdog";
      errors++;
      $display("FAIL %s timeout actual=1 expected=0", cur_req);
      finish_run();
   end

   initial begin
      int c;
      // R10 reset state
      step(3);
      @(negedge clk);
      chk("reset bclk", bclk, 0);
      chk("reset bit_stb", bit_stb, 0);
      chk("reset tx_stb", tx_stb, 0);
      chk("reset fs_tx", fs_tx, 0);
      chk("reset fs_rx", fs_rx, 1);
      step(1);
      rst_n = 1'b1;
      step(2);

      // R1 divider of 4, then odd and zero divisors
      cur_req = "R1";
      set_cfg(3, 0, 7, 1);
      step(1);
      gen_en = 1'b1;
      c = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (bit_stb) c++;
      end
      chk("bit_stb count div=3", c, 15);
      step(1);
      set_cfg(4, 0, 7, 1);
      step(30);
      set_cfg(0, 0, 7, 1);
      step(12);

      // R2 inverted clock polarity
      cur_req = "R2";
      set_cfg(2, 0, 7, 1);
      step(6);
      clk_pol = 1'b0;
      step(30);
      clk_pol = 1'b1;

      // R3 R4 frame period and pulse width
      cur_req = "R4";
      gen_en = 1'b0;
      set_cfg(1, 1, 5, 1);
      step(1);
      fs_en = 1'b1;
      gen_en = 1'b1;
      c = 0;
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         if (fs_tx) c++;
      end
      chk("fs active cycles", c, 40);
      step(1);
      cur_req = "R3";
      step(30);
      cur_req = "R4";
      set_cfg(1, 9, 5, 1);
      step(40);

      // R5 independent sync polarities
      cur_req = "R5";
      set_cfg(1, 1, 5, 1);
      fs_pol_tx = 1'b1;
      fs_pol_rx = 1'b0;
      c = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (fs_tx == fs_rx) c++;
      end
      chk("tx/rx sync complementary", c, 0);
      step(1);

      // R8 mid-frame reconfiguration
      cur_req = "R8";
      step(5);
      set_cfg(2, 0, 3, 1);
      step(60);

      // R6 request-paced frames
      cur_req = "R6";
      gen_en = 1'b0;
      set_cfg(1, 0, 3, 0);
      step(1);
      gen_en = 1'b1;
      c = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!fs_tx) c++;
      end
      chk("no frame without request", c, 0);
      step(1);
      xfer_req = 1'b1;
      step(1);
      xfer_req = 1'b0;
      step(30);
      xfer_req = 1'b1;
      step(1);
      xfer_req = 1'b0;
      step(20);

      // R7 enables
      cur_req = "R7";
      set_cfg(1, 0, 3, 1);
      step(12);
      fs_en = 1'b0;
      step(20);
      gen_en = 1'b0;
      c = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (bit_stb || tx_stb || bclk) c++;
      end
      chk("generator off quiet", c, 0);
      step(1);

      // R9 alternate clock source
      cur_req = "R9";
      src_sel = 1'b1;
      fs_en = 1'b1;
      gen_en = 1'b1;
      c = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (bit_stb) c++;
      end
      chk("no tick without ext edges", c, 0);
      step(1);
      for (int i = 0; i < 40; i++) begin
         ext_clk = ~ext_clk;
         step(3);
      end
      src_sel = 1'b0;
      step(10);

      finish_run();
   end
endmodule